// File: doc/BRIEF.md
# Host-Side Strobed Bus Access Controller

This block lets a host reach the internal memory or I/O registers of a slave processor over an asynchronous, strobed bus, one single read or write at a time. The host side is a pair of valid/ready channels. A command channel carries direction, address and write data, and a response channel returns read data and an error flag. On the bus side the controller first asks for the bus with an active-low request line and waits for the active-low grant. It then asserts chip select, drives the address and, for writes, the data, and pulses the read or write strobe low. The slave pulls its ready line low while it works. The strobe stays low until the slave lets that line go high again.

All minimum setup, strobe-low, hold and strobe-high intervals are counted in host clock cycles from parameters. The grant and ready inputs are asynchronous to the host clock, and each passes through a two-flop synchronizer before the state machine uses it. From the moment grant is seen, the top address bit is forced high, so that even the first access after the request carries an address outside the shared multiprocessor region. If the slave never releases ready, a programmable cycle limit aborts the access and returns it with an error. While commands keep arriving back to back, the bus is held. Once the queue runs dry, the request is dropped, and the controller waits for grant to go away before it idles.

Back-pressure rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Once `cmd_valid` is raised, it and the command fields must stay steady until that edge. A response is offered with `rsp_valid` and holds `rsp_rdata` and `rsp_err` steady until `rsp_ready` is seen high. While the response waits, the bus stays owned with both strobes high.

Top module: `hostbus_master`

## Requirements
- R1: While `rst_n` is low, `bus_req_n`, `cs_n`, `rd_n` and `wr_n` are 1, and `data_oe`, `cmd_ready` and `rsp_valid` are 0.
- R2: `rd_n` or `wr_n` is driven low only while `bus_req_n` and `cs_n` are low and the synchronized `bus_gnt_n` is low.
- R3: Whenever a strobe is low, `addr` equals the accepted command address with bit AW-1 forced to 1.
- R4: A strobe stays low for at least WIDTH_CYC cycles and, unless aborted by R8, until `slave_rdy` has been seen low and then high through the synchronizer. It rises no earlier than two host edges after `slave_rdy` returns high.
- R5: On a read, `rsp_rdata` returns the value on `data_in` taken at the edge where the strobe is released, and `rsp_err` is 0.
- R6: On a write, `data_oe` is 1 and `data_out` carries the write data for at least SETUP_CYC cycles before `wr_n` falls, for the whole time `wr_n` is low, and for at least HOLD_CYC cycles after it rises. During those hold cycles `addr` is unchanged and `cs_n` is 0.
- R7: `rd_n` and `wr_n` are never low together, and between two strobes both stay high for at least RECOV_CYC cycles (RECOV_CYC at least 1).
- R8: If the strobe has been low for `tmo_limit`+1 cycles without ready being released, the strobe is raised and the response carries `rsp_err` = 1.
- R9: If a command is waiting at the end of the recovery interval, it runs without `bus_req_n` rising. Otherwise `bus_req_n` and `cs_n` go high, and a new request starts only after `bus_gnt_n` has been seen high.
- R10: Commands are taken only on `cmd_valid` and `cmd_ready` both high. `rsp_rdata` and `rsp_err` stay stable while `rsp_valid` is high and `rsp_ready` is low.
- R11: `data_oe` is 0 whenever `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_limit | input | TMO_W | Cycle limit on strobe-low time before abort |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Host accepts response |
| rsp_rdata | output | DW | Read data |
| rsp_err | output | 1 | Access aborted by timeout |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low, asynchronous |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr | output | AW | Bus address |
| data_out | output | DW | Write data to bus |
| data_oe | output | 1 | Data bus drive enable |
| data_in | input | DW | Read data from bus |
| slave_rdy | input | 1 | Slave ready; low means access in progress |

## Verification
A state machine that jumps or sticks shows up on the bus pins within one or two cycles. A strobe that falls before grant has been seen, or rises while the slave still holds ready low, breaks the bus rules on the next edge. A strobe that rises too soon after a release ends the high gap short. A stale latched command shows as a wrong address bit or a wrong data word during the strobe. A bad capture edge shows as a wrong word on the response port. A stuck timeout counter shows as a strobe that never rises, or as a false error flag on a normal access. Since every internal fault maps to a visible pin pattern, the bench watches the pins every cycle and then checks the returned words at each response.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RESP,
    ST_RECOV,
    ST_RELEASE
  } hbm_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hbm_sync2.sv
module hbm_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= INIT[b];
        stable_q <= INIT[b];
      end else begin
        meta_q   <= d[b];
        stable_q <= meta_q;
      end
    end

    assign q[b] = stable_q;
  end

endmodule

// File: rtl/hbm_interval.sv
module hbm_interval #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/hbm_stall_timer.sv
module hbm_stall_timer #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (cnt_q != limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = en && (cnt_q == limit);

  // R8
  stall_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(limit) && $past(en)) |-> (cnt_q <= limit));

endmodule

// File: rtl/hostbus_master.sv
module hostbus_master
  import hbm_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned WIDTH_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned RECOV_CYC = 1,
  parameter int unsigned TMO_W     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          bus_req_n,
  input  logic          bus_gnt_n,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] data_in,
  input  logic          slave_rdy
);

  localparam int unsigned MAX_CYC = max4(SETUP_CYC, WIDTH_CYC, HOLD_CYC, RECOV_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [AW-1:0] MARK_MASK = {1'b1, {(AW-1){1'b0}}};
  localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] WIDTH_V = CNT_W'(WIDTH_CYC);
  localparam logic [CNT_W-1:0] HOLD_V  = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] RECOV_V = CNT_W'((RECOV_CYC < 1) ? 1 : RECOV_CYC);

  hbm_state_e state_q, state_d;

  logic          gnt_n_s, rdy_s;
  logic          ivl_load, ivl_done;
  logic [CNT_W-1:0] ivl_val;
  logic          tmo_exp;
  logic          accept, capture, abort;
  logic          cur_write_q;
  logic [AW-1:0] cur_addr_q;
  logic [DW-1:0] cur_wdata_q;
  logic [DW-1:0] rdata_q;
  logic          err_q;
  logic          busy_seen_q;
  logic          strobe_on;
  logic          drive_phase;

  // Asynchronous grant and ready inputs, two flops each.
  hbm_sync2 #(.W(2), .INIT(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_gnt_n, slave_rdy}),
    .q     ({gnt_n_s, rdy_s})
  );

  hbm_interval #(.W(CNT_W)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ivl_load),
    .load_val (ivl_val),
    .done     (ivl_done)
  );

  hbm_stall_timer #(.W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state_q == ST_STROBE),
    .limit   (tmo_limit),
    .expired (tmo_exp)
  );

  // Next-state and interval loading.
  always_comb begin
    state_d  = state_q;
    ivl_load = 1'b0;
    ivl_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    abort    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (!gnt_n_s) begin
          accept   = 1'b1;
          state_d  = ST_SETUP;
          ivl_load = 1'b1;
          ivl_val  = SETUP_V;
        end
      end
      ST_SETUP: begin
        if (ivl_done) begin
          state_d  = ST_STROBE;
          ivl_load = 1'b1;
          ivl_val  = WIDTH_V;
        end
      end
      ST_STROBE: begin
        if (tmo_exp) begin
          abort    = 1'b1;
          state_d  = ST_HOLD;
          ivl_load = 1'b1;
          ivl_val  = HOLD_V;
        end else if (ivl_done && busy_seen_q && rdy_s) begin
          capture  = 1'b1;
          state_d  = ST_HOLD;
          ivl_load = 1'b1;
          ivl_val  = HOLD_V;
        end
      end
      ST_HOLD: begin
        if (ivl_done) state_d = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_ready) begin
          state_d  = ST_RECOV;
          ivl_load = 1'b1;
          ivl_val  = RECOV_V;
        end
      end
      ST_RECOV: begin
        if (ivl_done) begin
          if (cmd_valid) begin
            accept   = 1'b1;
            state_d  = ST_SETUP;
            ivl_load = 1'b1;
            ivl_val  = SETUP_V;
          end else begin
            state_d = ST_RELEASE;
          end
        end
      end
      ST_RELEASE: begin
        if (gnt_n_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_write_q <= 1'b0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
      busy_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_write_q <= cmd_write;
        cur_addr_q  <= cmd_addr;
        cur_wdata_q <= cmd_wdata;
        err_q       <= 1'b0;
      end
      if (capture && !cur_write_q) rdata_q <= data_in;
      if (abort) err_q <= 1'b1;
      if (state_d == ST_STROBE && state_q != ST_STROBE) begin
        busy_seen_q <= 1'b0;
      end else if (state_q == ST_STROBE && !rdy_s) begin
        busy_seen_q <= 1'b1;
      end
    end
  end

  // Bus-side decode.
  assign strobe_on   = (state_q == ST_STROBE);
  assign drive_phase = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);

  assign bus_req_n = (state_q == ST_IDLE) || (state_q == ST_RELEASE);
  assign cs_n      = (state_q == ST_IDLE) || (state_q == ST_RELEASE);
  assign rd_n      = !(strobe_on && !cur_write_q);
  assign wr_n      = !(strobe_on && cur_write_q);
  assign addr      = ((state_q == ST_IDLE) || (state_q == ST_REQ) || (state_q == ST_RELEASE))
                     ? '0 : (cur_addr_q | MARK_MASK);
  assign data_out  = cur_wdata_q;
  assign data_oe   = cur_write_q && drive_phase;

  // Host-side channels.
  assign cmd_ready = accept;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  // R2
  strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!bus_req_n && !cs_n && !gnt_n_s));

  // R3
  mark_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> addr[AW-1]);

  // R4
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> ($past(rdy_s) || $past(tmo_exp)));

  // R7
  read_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |=> (rd_n && wr_n));

  // R7
  write_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |=> (rd_n && wr_n));

  // R6
  cs_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (!cs_n && data_oe));

  // R11
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !data_oe);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  // R9
  release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req_n) && !bus_req_n) |-> $past(gnt_n_s));

endmodule

// File: tb/hostbus_master_tb_top.sv
module hostbus_master_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SETUP_CYC = 2;
  localparam int WIDTH_CYC = 2;
  localparam int HOLD_CYC  = 1;
  localparam int RECOV_CYC = 1;
  localparam int TMO_W     = 12;
  localparam logic [AW-1:0] MARK = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TMO_W-1:0] tmo_limit = 12'd200;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic bus_req_n, bus_gnt_n = 1'b1, cs_n, rd_n, wr_n, data_oe;
  logic [AW-1:0] addr;
  logic [DW-1:0] data_out;
  logic [DW-1:0] data_in = '0;
  logic slave_rdy = 1'b1;

  always #5 clk = ~clk;

  hostbus_master #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC),
    .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC), .TMO_W(TMO_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
    .slave_rdy(slave_rdy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Monitor / model state
  logic [DW-1:0] smem [16];
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_wdata = '0;
  int v2 = 0, v3 = 0, v4 = 0, v6 = 0, v7 = 0, v11 = 0;
  int req_rises = 0;
  int gnt_delay = 2, gcnt = 0;
  int sl_delay = 1, sl_busy = 3, sl_phase = 0, sl_cnt = 0, rel_age = 0;
  bit stall = 1'b0;
  int low_cnt = 0, last_low = 0, high_gap = 100, setup_cnt = 0, hold_left = 0;
  logic [AW-1:0] hold_addr = '0;
  logic prev_rd = 1'b1, prev_wr = 1'b1, prev_req = 1'b1;
  bit rose_while_busy = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Slave, grant and bus-rule monitor, all at the falling edge.
  initial begin
    for (int i = 0; i < 16; i++) smem[i] = 32'h1000_0000 + 32'(i * 32'h0101);
    forever begin
      @(negedge clk);
      if (rst_n) begin
        automatic bit slow  = !rd_n || !wr_n;
        automatic bit pslow = !prev_rd || !prev_wr;
        if (slow && (bus_req_n || cs_n || bus_gnt_n)) v2++;
        if (slow && addr !== (exp_addr | MARK)) v3++;
        if (!rd_n && !wr_n) v7++;
        if (!rd_n && data_oe) v11++;
        if (slow && !pslow) begin
          if (high_gap < RECOV_CYC) v7++;
          if (!wr_n && setup_cnt < SETUP_CYC) v6++;
          low_cnt = 0;
        end
        if (!wr_n && (!data_oe || data_out !== exp_wdata || cs_n)) v6++;
        if (data_oe && wr_n) setup_cnt++;
        else if (!data_oe) setup_cnt = 0;
        if (slow) low_cnt++;
        if (!slow && pslow) begin
          last_low = low_cnt;
          if (low_cnt < WIDTH_CYC) v4++;
          if (!stall && (sl_phase != 3 || rel_age < 2)) v4++;
          rose_while_busy = (slave_rdy == 1'b0);
          if (!prev_wr) begin
            if (cs_n) v6++;
            smem[addr[3:0]] = data_out;
            hold_left = HOLD_CYC;
            hold_addr = addr;
          end
          high_gap = 1;
        end else if (!slow && high_gap < 100) begin
          high_gap++;
        end
        if (hold_left > 0) begin
          if (!data_oe || cs_n || addr !== hold_addr || data_out !== exp_wdata) v6++;
          hold_left--;
        end
        if (bus_req_n && !prev_req) req_rises++;
        // slave model
        if (!slow) begin
          slave_rdy = 1'b1;
          sl_phase  = 0;
        end else begin
          case (sl_phase)
            0: begin sl_cnt = sl_delay; sl_phase = 1; end
            1: if (sl_cnt == 0) begin slave_rdy = 1'b0; sl_cnt = sl_busy; sl_phase = 2; end
               else sl_cnt--;
            2: if (!stall) begin
                 if (sl_cnt == 0) begin slave_rdy = 1'b1; sl_phase = 3; rel_age = 0; end
                 else sl_cnt--;
               end
            default: rel_age++;
          endcase
        end
        if (!rd_n) data_in = smem[addr[3:0]];
        // grant model
        if (!bus_req_n) begin
          if (bus_gnt_n) begin
            if (gcnt >= gnt_delay) bus_gnt_n = 1'b0;
            else gcnt++;
          end
        end else begin
          bus_gnt_n = 1'b1;
          gcnt = 0;
        end
        prev_rd  = rd_n;
        prev_wr  = wr_n;
        prev_req = bus_req_n;
      end
    end
  end

  task automatic send_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    exp_addr = a; exp_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_rsp(output logic [DW-1:0] d, output logic e);
    rsp_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata; e = rsp_err;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (!bus_req_n && n < 40) begin @(negedge clk); n++; end
    check(bus_req_n && cs_n, tag, {bus_req_n, cs_n}, 2'b11);
    repeat (6) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(bus_req_n && cs_n && rd_n && wr_n, "R1 strobes/select idle", {bus_req_n, cs_n, rd_n, wr_n}, 4'hf);
    check(!data_oe && !cmd_ready && !rsp_valid, "R1 enables low", {data_oe, cmd_ready, rsp_valid}, 3'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_write_read();
    logic [DW-1:0] d; logic e;
    send_cmd(1'b1, 32'h0000_0003, 32'hA5A5_0003);
    get_rsp(d, e);
    check(e == 1'b0, "R6 write no error", e, 0);
    check(smem[3] == 32'hA5A5_0003, "R6 slave stored write", smem[3], 32'hA5A5_0003);
    wait_idle("R9 release after write");
    send_cmd(1'b0, 32'h0000_0003, '0);
    get_rsp(d, e);
    // R5
    check(d == 32'hA5A5_0003 && !e, "R5 read back", d, 32'hA5A5_0003);
    wait_idle("R9 release after read");
    send_cmd(1'b0, 32'h0000_0009, '0);
    get_rsp(d, e);
    check(d == smem[9], "R5 preset word", d, smem[9]);
    wait_idle("R9 release after read 2");
    check(v3 == 0, "R3 address with mark bit", v3, 0);
    check(v6 == 0, "R6 write data window", v6, 0);
    check(v11 == 0, "R11 no drive on read", v11, 0);
  endtask

  task automatic test_slow_grant();
    logic [DW-1:0] d; logic e;
    gnt_delay = 12;
    send_cmd(1'b0, 32'h0000_0007, '0);
    get_rsp(d, e);
    check(d == smem[7], "R2 read after slow grant", d, smem[7]);
    wait_idle("R9 release slow grant");
    gnt_delay = 2;
    check(v2 == 0, "R2 strobe only with grant", v2, 0);
  endtask

  task automatic test_slow_slave();
    logic [DW-1:0] d; logic e;
    sl_delay = 0; sl_busy = 15;
    send_cmd(1'b0, 32'h0000_000C, '0);
    get_rsp(d, e);
    check(d == smem[12] && !e, "R4 long wait read", d, smem[12]);
    check(last_low >= 17, "R4 strobe spans busy time", last_low, 17);
    wait_idle("R9 release slow slave");
    sl_delay = 1; sl_busy = 3;
    check(v4 == 0, "R4 strobe released only after ready", v4, 0);
  endtask

  task automatic test_back_to_back();
    logic [DW-1:0] d; logic e;
    int r0;
    send_cmd(1'b1, 32'h0000_0005, 32'h5555_0005);
    r0 = req_rises;
    get_rsp(d, e);
    send_cmd(1'b0, 32'h0000_0005, '0);
    get_rsp(d, e);
    // R9
    check(req_rises == r0, "R9 bus held between queued accesses", req_rises - r0, 0);
    check(d == 32'h5555_0005, "R5 read after queued write", d, 32'h5555_0005);
    wait_idle("R9 release after queue");
    check(v7 == 0, "R7 strobe high gap", v7, 0);
  endtask

  task automatic test_backpressure();
    logic [DW-1:0] d0; logic e; bit ok;
    send_cmd(1'b0, 32'h0000_0002, '0);
    rsp_ready = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_rdata;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_rdata !== d0 || cs_n || !rd_n) ok = 1'b0;
    end
    // R10
    check(ok, "R10 response held under back-pressure", ok, 1);
    check(d0 == smem[2], "R10 held word", d0, smem[2]);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    check(!rsp_valid, "R10 response taken once", rsp_valid, 0);
    wait_idle("R9 release after back-pressure");
  endtask

  task automatic test_timeout();
    logic [DW-1:0] d; logic e;
    tmo_limit = 12'd12;
    stall = 1'b1;
    send_cmd(1'b0, 32'h0000_0004, '0);
    get_rsp(d, e);
    // R8
    check(e == 1'b1, "R8 timeout error flag", e, 1);
    check(last_low <= 13 && rose_while_busy, "R8 strobe aborted", last_low, 13);
    wait_idle("R9 release after timeout");
    stall = 1'b0;
    send_cmd(1'b1, 32'h0000_0001, 32'hCAFE_0001);
    get_rsp(d, e);
    check(e == 1'b0, "R8 error clears on next access", e, 0);
    wait_idle("R9 release after recovery");
    tmo_limit = 12'd200;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_write_read();
    test_slow_grant();
    test_slow_slave();
    test_back_to_back();
    test_backpressure();
    test_timeout();
    check(v2 == 0 && v3 == 0 && v6 == 0 && v7 == 0 && v11 == 0, "R2 R3 R6 R7 R11 final bus rules",
          v2 + v3 + v6 + v7 + v11, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule